// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at every opcode-fetch cycle of a small 8-bit processor core, whether the fetched opcode runs or is thrown away in favour of an interrupt entry. It also produces the bus cycles of that entry. A maskable request is level sensitive. A non-maskable request is edge sensitive and is remembered in a pending flag, so a single-cycle low pulse is enough. A software break opcode reaches the same entry path. Each entry takes seven cycles: the opcode fetch that is discarded, a dummy read, three writes to the stack page (PC high, PC low, status), and two reads of the vector with a vector-pull strobe. The next cycle is a fetch at the vector target.

Arbitration takes place only at a fetch. Once an entry has started, its vector is fixed and cannot be taken over. A non-maskable request that arrives during an entry waits in its pending flag and is served at the fetch right after the vector-high read. A taken branch holds off recognition for one instruction. Normal execution uses a stub. A plain opcode takes two cycles: the fetch, then a read at PC+1, with the next fetch at PC+1. A taken branch takes three cycles, with the next fetch at PC+2. The `i_clear` input stands in for the instructions that clear the mask.

The states are `ST_FETCH`, `ST_EXEC`, `ST_BR_OPND`, `ST_BR_FIX`, `ST_DUMMY`, `ST_PUSH_H`, `ST_PUSH_L`, `ST_PUSH_P`, `ST_VEC_L` and `ST_VEC_H`. The transitions are:
- `ST_FETCH` goes to `ST_DUMMY` when an entry is chosen, to `ST_BR_OPND` on a taken branch, and to `ST_EXEC` otherwise.
- `ST_EXEC` goes to `ST_FETCH`.
- `ST_BR_OPND` goes to `ST_BR_FIX`, which goes to `ST_FETCH`.
- The entry states run in a fixed chain: `ST_DUMMY` → `ST_PUSH_H` → `ST_PUSH_L` → `ST_PUSH_P` → `ST_VEC_L` → `ST_VEC_H` → `ST_FETCH`.

Top module: `irq_entry_seq`

## Requirements
- R1: During reset and in the first cycle after it, the outputs show a fetch at RESET_PC (0x0200), with `sync`=1, `wr_en`=0, `vec_pull`=0, `i_flag`=1, and the stack pointer at 0xFF.
- R2: A plain opcode fetched at P gives a read at P+1 with `sync`=0, then a fetch at P+1. An opcode fetched while `br_taken`=1 gives reads at P+1 and P+2, then a fetch at P+2.
- R3: An `irq_n` level that is low at the clock edge ending cycle k can start an entry only at a fetch in cycle k+2 or later; the fetch in cycle k+1 runs normally. While `i_flag`=1, `irq_n` has no effect.
- R4: An `nmi_n` low for a single cycle sets a pending request with the same latency as R3, and `i_flag` does not mask it. Starting the entry clears the pending flag. Holding `nmi_n` low produces exactly one entry.
- R5: An entry from a fetch at P consists of the following cycles, in order. First, a dummy read at P for a hardware request (P+1 for a break). Next come writes of PC[15:8], PC[7:0] and status to 0x0100+SP, SP-1 and SP-2. Last come the reads of vector low and vector high with `vec_pull`=1. The following cycle fetches at {high,low}, and SP has dropped by 3.
- R6: The pushed status equals `flags_in` with bit 5 forced to 1, bit 4 set to 1 only for a break, and bit 2 holding `i_flag` from before the entry. `i_flag` is 1 by the vector reads.
- R7: A break opcode (`brk_op`=1 at the fetch) increments the PC twice, pushes P+2 and uses the 0xFFFE/0xFFFF vector. A maskable request raised during the break leaves it unchanged.
- R8: Non-maskable entries read the vector at 0xFFFA/0xFFFB. Maskable and break entries read it at 0xFFFE/0xFFFF.
- R9: When both are recognised at the same fetch, the non-maskable request wins over the maskable one, and the maskable one wins over a break opcode. A break that loses is not incremented and pushes bit 4 clear.
- R10: A request that arrives after an entry has begun does not change that entry's vector. A pending non-maskable request begins its entry at the fetch directly after the vector-high read.
- R11: At the first fetch after a taken branch, no hardware request is recognised. Recognition resumes at the fetch after that.
- R12: `i_clear`=1 clears `i_flag` at the next edge. If `i_clear` coincides with the status push, the entry's setting of the mask wins.
- R13: `wr_en` is high only during the three pushes, and only to page 0x01. `vec_pull` is high only during the two vector reads, and never together with `sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| brk_op | input | 1 | Fetched opcode decodes as break (valid in fetch cycles) |
| br_taken | input | 1 | Fetched opcode is a taken branch (valid in fetch cycles) |
| i_clear | input | 1 | Clear the interrupt mask |
| flags_in | input | 8 | Status flags from the execution unit |
| rdata | input | 8 | Read data bus |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data bus |
| wr_en | output | 1 | Write strobe |
| sync | output | 1 | Opcode-fetch cycle marker |
| vec_pull | output | 1 | Vector-read strobe |
| i_flag | output | 1 | Interrupt mask flag |

## Verification
Take an `irq_n` or `nmi_n` change applied during cycle k. The first fetch that can react to it is the one in cycle k+2, and the dummy read that proves the entry appears one cycle after that fetch. The pushes follow at fetch+2 to +4, the vector reads at +5 and +6, and the handler fetch at +7. Every scenario task starts from a reset so that its cycle count is known. It places each stimulus at the falling clock edge of a chosen cycle. It then checks the full bus on every following cycle against addresses and data computed from the requirements, which catches an entry that starts one cycle early or late. Mask and pending effects, such as a late request or a held line, are checked on the bus of the cycles in which they could have acted.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_EXEC,
        ST_BR_OPND,
        ST_BR_FIX,
        ST_DUMMY,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IRQ,
        SRC_NMI,
        SRC_BRK
    } entry_src_t;

    // Status byte as written to the stack: bit 5 always set,
    // bit 4 marks a software break, bit 2 carries the mask.
    function automatic logic [7:0] make_status(input logic [7:0] flags,
                                               input logic       is_brk,
                                               input logic       mask);
        logic [7:0] s;
        s    = flags;
        s[5] = 1'b1;
        s[4] = is_brk;
        s[2] = mask;
        return s;
    endfunction

endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic nmi_ack,
    output logic irq_seen,
    output logic nmi_pend
);
    localparam int S = (STAGES < 2) ? 2 : STAGES;

    logic [S-1:0] irq_sh;
    logic [S-1:0] nmi_sh;
    logic         nmi_fall;

    // Active-high copies of the lines, delayed by S edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sh <= '0;
            nmi_sh <= '0;
        end else begin
            irq_sh <= {irq_sh[S-2:0], ~irq_n};
            nmi_sh <= {nmi_sh[S-2:0], ~nmi_n};
        end
    end

    assign irq_seen = irq_sh[S-1];
    assign nmi_fall = nmi_sh[S-2] & ~nmi_sh[S-1];

    // A fresh edge beats the acknowledge of an older one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend <= 1'b0;
        end else if (nmi_fall) begin
            nmi_pend <= 1'b1;
        end else if (nmi_ack) begin
            nmi_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
    import irq_entry_pkg::*;
(
    input  logic       irq_seen,
    input  logic       nmi_pend,
    input  logic       i_mask,
    input  logic       brk_op,
    input  logic       hold,
    output entry_src_t src
);
    always_comb begin
        src = SRC_NONE;
        if (!hold && nmi_pend) begin
            src = SRC_NMI;
        end else if (!hold && irq_seen && !i_mask) begin
            src = SRC_IRQ;
        end else if (brk_op) begin
            src = SRC_BRK;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              DW            = 8,
    parameter logic [DW-1:0]   STACK_PAGE    = 8'h01,
    parameter logic [DW-1:0]   RESET_SP      = 8'hFF,
    parameter logic [2*DW-1:0] RESET_PC      = 16'h0200,
    parameter int              SAMPLE_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_n,
    input  logic            nmi_n,
    input  logic            brk_op,
    input  logic            br_taken,
    input  logic            i_clear,
    input  logic [DW-1:0]   flags_in,
    input  logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] addr,
    output logic [DW-1:0]   wdata,
    output logic            wr_en,
    output logic            sync,
    output logic            vec_pull,
    output logic            i_flag
);
    localparam int             AW      = 2 * DW;
    localparam logic [AW-1:0]  VEC_NMI = {AW{1'b1}} - AW'(5);
    localparam logic [AW-1:0]  VEC_IRQ = {AW{1'b1}} - AW'(1);

    seq_state_t    state_q, state_d;
    entry_src_t    src_q, pick;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] vec_lo_q;
    logic          i_q;
    logic          hold_q;
    logic          irq_seen, nmi_pend, nmi_ack;
    logic [AW-1:0] vec_base;

    irq_line_sampler #(.STAGES(SAMPLE_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .nmi_n    (nmi_n),
        .nmi_ack  (nmi_ack),
        .irq_seen (irq_seen),
        .nmi_pend (nmi_pend)
    );

    entry_arbiter u_arbiter (
        .irq_seen (irq_seen),
        .nmi_pend (nmi_pend),
        .i_mask   (i_q),
        .brk_op   (brk_op),
        .hold     (hold_q),
        .src      (pick)
    );

    assign nmi_ack  = (state_q == ST_FETCH) && (pick == SRC_NMI);
    assign vec_base = (src_q == SRC_NMI) ? VEC_NMI : VEC_IRQ;
    assign i_flag   = i_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (pick != SRC_NONE) state_d = ST_DUMMY;
                else if (br_taken)    state_d = ST_BR_OPND;
                else                  state_d = ST_EXEC;
            end
            ST_EXEC:    state_d = ST_FETCH;
            ST_BR_OPND: state_d = ST_BR_FIX;
            ST_BR_FIX:  state_d = ST_FETCH;
            ST_DUMMY:   state_d = ST_PUSH_H;
            ST_PUSH_H:  state_d = ST_PUSH_L;
            ST_PUSH_L:  state_d = ST_PUSH_P;
            ST_PUSH_P:  state_d = ST_VEC_L;
            ST_VEC_L:   state_d = ST_VEC_H;
            ST_VEC_H:   state_d = ST_FETCH;
            default:    state_d = ST_FETCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            sp_q     <= RESET_SP;
            src_q    <= SRC_NONE;
            vec_lo_q <= '0;
            hold_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    hold_q <= 1'b0;
                    src_q  <= pick;
                    if (pick == SRC_NONE || pick == SRC_BRK) pc_q <= pc_q + AW'(1);
                end
                ST_BR_OPND: begin
                    pc_q   <= pc_q + AW'(1);
                    hold_q <= 1'b1;
                end
                ST_DUMMY: begin
                    if (src_q == SRC_BRK) pc_q <= pc_q + AW'(1);
                end
                ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: begin
                    sp_q <= sp_q - DW'(1);
                end
                ST_VEC_L: begin
                    vec_lo_q <= rdata;
                end
                ST_VEC_H: begin
                    pc_q <= {rdata, vec_lo_q};
                end
                default: begin
                end
            endcase
        end
    end

    // Interrupt mask: entry sets it at the status push, ahead of a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                   i_q <= 1'b1;
        else if (state_q == ST_PUSH_P) i_q <= 1'b1;
        else if (i_clear)             i_q <= 1'b0;
    end

    // Bus outputs
    always_comb begin
        addr     = pc_q;
        wdata    = '0;
        wr_en    = 1'b0;
        sync     = 1'b0;
        vec_pull = 1'b0;
        unique case (state_q)
            ST_FETCH:   sync = 1'b1;
            ST_EXEC, ST_BR_OPND, ST_BR_FIX, ST_DUMMY: addr = pc_q;
            ST_PUSH_H: begin
                addr  = {STACK_PAGE, sp_q};
                wdata = pc_q[AW-1:DW];
                wr_en = 1'b1;
            end
            ST_PUSH_L: begin
                addr  = {STACK_PAGE, sp_q};
                wdata = pc_q[DW-1:0];
                wr_en = 1'b1;
            end
            ST_PUSH_P: begin
                addr  = {STACK_PAGE, sp_q};
                wdata = make_status(flags_in, src_q == SRC_BRK, i_q);
                wr_en = 1'b1;
            end
            ST_VEC_L: begin
                addr     = vec_base;
                vec_pull = 1'b1;
            end
            ST_VEC_H: begin
                addr     = vec_base | AW'(1);
                vec_pull = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*DW-1:0] addr,
    input logic            wr_en,
    input logic            sync,
    input logic            vec_pull,
    input logic            i_flag
);
    localparam int AW = 2 * DW;

    assert_stack_page_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr[AW-1:DW] == STACK_PAGE));

    assert_sync_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (!wr_en && !vec_pull));

    assert_vector_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull |-> ((&addr[AW-1:3]) && !wr_en));

    assert_push_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (addr[DW-1:0] == $past(addr[DW-1:0]) - 1'b1));

    assert_vec_after_pushes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && $past(wr_en, 2)) |=> vec_pull);

    assert_fetch_after_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pull && $past(vec_pull)) |=> (sync && !vec_pull));

    assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull |-> i_flag);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .sync     (sync),
    .vec_pull (vec_pull),
    .i_flag   (i_flag)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic        nmi_n = 1'b1;
    logic        i_clear = 1'b0;
    logic [7:0]  flags_in = 8'h02;
    logic [7:0]  rdata;
    logic        brk_op, br_taken;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        wr_en, sync, vec_pull, i_flag;
    logic [15:0] brk_at = 16'hFFFF;
    logic [15:0] br_at  = 16'hFFFF;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // Memory model: vectors point to 0x3000 (NMI) and 0x4000 (IRQ/BRK)
    always_comb begin
        case (addr)
            16'hFFFA: rdata = 8'h00;
            16'hFFFB: rdata = 8'h30;
            16'hFFFE: rdata = 8'h00;
            16'hFFFF: rdata = 8'h40;
            default:  rdata = 8'hEA;
        endcase
    end
    assign brk_op   = (addr == brk_at);
    assign br_taken = (addr == br_at);

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .brk_op(brk_op), .br_taken(br_taken), .i_clear(i_clear),
        .flags_in(flags_in), .rdata(rdata), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .sync(sync), .vec_pull(vec_pull), .i_flag(i_flag)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Check the current cycle's bus, then advance one cycle.
    task automatic bus(string tag, logic [15:0] a, logic we, logic [7:0] wd,
                       logic sy, logic vp);
        chk(tag, "addr", addr, a);
        chk(tag, "wr_en", 16'(wr_en), 16'(we));
        chk(tag, "sync", 16'(sync), 16'(sy));
        chk(tag, "vec_pull", 16'(vec_pull), 16'(vp));
        if (we) chk(tag, "wdata", 16'(wdata), 16'(wd));
        @(negedge clk);
        i_clear = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; i_clear = 1'b0;
        brk_at = 16'hFFFF; br_at = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called in the fetch cycle that opens an entry; returns at the handler fetch.
    task automatic entry(string tag, logic [15:0] fa, logic [15:0] da,
                         logic [15:0] ppc, logic [7:0] sp, logic [7:0] st,
                         logic [15:0] va, bit clr_psw, bit nmi_dummy);
        bus(tag, fa, 0, 0, 1, 0);
        if (nmi_dummy) nmi_n = 1'b0;
        bus(tag, da, 0, 0, 0, 0);
        nmi_n = 1'b1;
        bus(tag, {8'h01, sp}, 1, ppc[15:8], 0, 0);
        bus(tag, {8'h01, sp - 8'd1}, 1, ppc[7:0], 0, 0);
        if (clr_psw) i_clear = 1'b1;
        bus(tag, {8'h01, sp - 8'd2}, 1, st, 0, 0);
        bus(tag, va, 0, 0, 0, 1);
        bus(tag, va | 16'h1, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "sync", 16'(sync), 16'd1);
        chk("R1", "addr", addr, 16'h0200);
        chk("R1", "wr_en", 16'(wr_en), 16'd0);
        chk("R1", "vec_pull", 16'(vec_pull), 16'd0);
        chk("R1", "i_flag", 16'(i_flag), 16'd1);
    endtask

    // R2 stub flow and R11 taken-branch delay
    task automatic t_branch_delay();
        do_reset();
        br_at = 16'h0201;
        i_clear = 1'b1;
        bus("R2", 16'h0200, 0, 0, 1, 0);
        bus("R2", 16'h0201, 0, 0, 0, 0);
        irq_n = 1'b0;
        bus("R2", 16'h0201, 0, 0, 1, 0);
        bus("R2", 16'h0202, 0, 0, 0, 0);
        bus("R2", 16'h0203, 0, 0, 0, 0);
        bus("R11", 16'h0203, 0, 0, 1, 0);
        bus("R11", 16'h0204, 0, 0, 0, 0);
        entry("R11", 16'h0204, 16'h0204, 16'h0204, 8'hFF, 8'h22, 16'hFFFE, 0, 0);
        chk("R5", "handler fetch", addr, 16'h4000);
        irq_n = 1'b1;
    endtask

    // R3 latency and mask, R12 clear and set-wins
    task automatic t_irq_timing();
        do_reset();
        i_clear = 1'b1;
        bus("R3", 16'h0200, 0, 0, 1, 0);
        irq_n = 1'b0;
        bus("R3", 16'h0201, 0, 0, 0, 0);
        bus("R3", 16'h0201, 0, 0, 1, 0);
        bus("R3", 16'h0202, 0, 0, 0, 0);
        entry("R3", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h22, 16'hFFFE, 1, 0);
        chk("R12", "i_flag set wins", 16'(i_flag), 16'd1);
        bus("R3", 16'h4000, 0, 0, 1, 0);
        bus("R3", 16'h4001, 0, 0, 0, 0);
        bus("R3", 16'h4001, 0, 0, 1, 0);
        bus("R3", 16'h4002, 0, 0, 0, 0);
        i_clear = 1'b1;
        bus("R12", 16'h4002, 0, 0, 1, 0);
        chk("R12", "i_flag cleared", 16'(i_flag), 16'd0);
        bus("R12", 16'h4003, 0, 0, 0, 0);
        entry("R5", 16'h4003, 16'h4003, 16'h4003, 8'hFC, 8'h22, 16'hFFFE, 0, 0);
        irq_n = 1'b1;
    endtask

    task automatic t_nmi_pulse();
        do_reset();
        bus("R4", 16'h0200, 0, 0, 1, 0);
        nmi_n = 1'b0;
        bus("R4", 16'h0201, 0, 0, 0, 0);
        nmi_n = 1'b1;
        bus("R4", 16'h0201, 0, 0, 1, 0);
        bus("R4", 16'h0202, 0, 0, 0, 0);
        entry("R8", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h26, 16'hFFFA, 0, 0);
        bus("R4", 16'h3000, 0, 0, 1, 0);
        bus("R4", 16'h3001, 0, 0, 0, 0);
        bus("R4", 16'h3001, 0, 0, 1, 0);
        bus("R4", 16'h3002, 0, 0, 0, 0);
    endtask

    task automatic t_nmi_held();
        do_reset();
        bus("R4", 16'h0200, 0, 0, 1, 0);
        nmi_n = 1'b0;
        bus("R4", 16'h0201, 0, 0, 0, 0);
        bus("R4", 16'h0201, 0, 0, 1, 0);
        bus("R4", 16'h0202, 0, 0, 0, 0);
        entry("R4", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h26, 16'hFFFA, 0, 0);
        for (int n = 0; n < 3; n++) begin
            bus("R4", 16'h3000 + 16'(n), 0, 0, 1, 0);
            bus("R4", 16'h3001 + 16'(n), 0, 0, 0, 0);
        end
        nmi_n = 1'b1;
    endtask

    task automatic t_priority();
        do_reset();
        i_clear = 1'b1;
        bus("R9", 16'h0200, 0, 0, 1, 0);
        irq_n = 1'b0; nmi_n = 1'b0;
        bus("R9", 16'h0201, 0, 0, 0, 0);
        nmi_n = 1'b1;
        bus("R9", 16'h0201, 0, 0, 1, 0);
        bus("R9", 16'h0202, 0, 0, 0, 0);
        entry("R9", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h22, 16'hFFFA, 0, 0);
        bus("R9", 16'h3000, 0, 0, 1, 0);
        bus("R9", 16'h3001, 0, 0, 0, 0);
        irq_n = 1'b1;
        // maskable request beats a break opcode at the same fetch
        do_reset();
        brk_at = 16'h0202;
        i_clear = 1'b1;
        bus("R9", 16'h0200, 0, 0, 1, 0);
        irq_n = 1'b0;
        bus("R9", 16'h0201, 0, 0, 0, 0);
        bus("R9", 16'h0201, 0, 0, 1, 0);
        bus("R9", 16'h0202, 0, 0, 0, 0);
        entry("R9", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h22, 16'hFFFE, 0, 0);
        irq_n = 1'b1;
    endtask

    task automatic t_brk();
        do_reset();
        brk_at = 16'h0201;
        i_clear = 1'b1;
        bus("R7", 16'h0200, 0, 0, 1, 0);
        bus("R7", 16'h0201, 0, 0, 0, 0);
        irq_n = 1'b0;
        entry("R7", 16'h0201, 16'h0202, 16'h0203, 8'hFF, 8'h32, 16'hFFFE, 0, 0);
        bus("R6", 16'h4000, 0, 0, 1, 0);
        bus("R6", 16'h4001, 0, 0, 0, 0);
        irq_n = 1'b1;
    endtask

    task automatic t_late_nmi();
        do_reset();
        i_clear = 1'b1;
        bus("R10", 16'h0200, 0, 0, 1, 0);
        irq_n = 1'b0;
        bus("R10", 16'h0201, 0, 0, 0, 0);
        bus("R10", 16'h0201, 0, 0, 1, 0);
        bus("R10", 16'h0202, 0, 0, 0, 0);
        entry("R10", 16'h0202, 16'h0202, 16'h0202, 8'hFF, 8'h22, 16'hFFFE, 0, 1);
        entry("R10", 16'h4000, 16'h4000, 16'h4000, 8'hFC, 8'h26, 16'hFFFA, 0, 0);
        chk("R10", "nmi handler fetch", addr, 16'h3000);
        irq_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_branch_delay();
        t_irq_timing();
        t_nmi_pulse();
        t_nmi_held();
        t_priority();
        t_brk();
        t_late_nmi();
        finish_run();
    end

endmodule